// File: doc/BRIEF.md
# Warp Issue Scheduler with Block Barrier

This block sits in one shader core and owns a fixed pool of warp execution contexts. A work dispatcher asks for room for a thread block by giving its thread count; the block turns that count into 32-thread warps, claims enough free contexts in one step and tags each claimed warp with its block and its position inside the block. Threads 0 to 31 of a block land in the warp of position 0, threads 32 to 63 in position 1, and so on.

Every clock the block picks at most one runnable warp to issue, in round-robin order starting after the last warp it issued. A warp is runnable when it is allocated, not finished, not stalled and not held at a barrier. A warp that arrives at a block barrier is held until every unfinished warp of its block has arrived; the whole block is then released together. When every warp of a block has finished, all of its contexts return to the free pool.

Top module: `warp_issue_sched`

## Requirements
- R1: While rst_ni is low no warp is allocated, issue_valid_o is 0 and alloc_grant_o is 0 when alloc_valid_i is 0.
- R2: alloc_grant_o is 1 in the same cycle exactly when alloc_valid_i is 1, alloc_threads_i is between 1 and NUM_WARPS*32, and the number of free contexts is at least ceil(alloc_threads_i/32); a granted block takes that many lowest-numbered free contexts, and alloc_block_o (0 when not granted) is the lowest of them, which becomes the block tag.
- R3: While issuing, issue_block_o is the issued warp's block tag and issue_lane_base_o is 32 times the warp's position in its block, positions counting up from 0 in ascending context order.
- R4: At most one warp issues per cycle; issue_valid_o is 0 in any cycle with no runnable warp, and then issue_warp_o, issue_block_o and issue_lane_base_o are 0. Newly granted warps are runnable from the next cycle.
- R5: The issued warp is the first runnable one found scanning upward (with wrap) from the warp after the last issued one; after reset the scan starts at warp 0.
- R6: A warp whose stall_i bit is 1 is not issued in that cycle.
- R7: A warp whose bar_arrive_i bit is 1 is not runnable from the next cycle until its block is released.
- R8: In the cycle where every unfinished warp of a block is waiting or arriving, all of them become runnable from the next cycle.
- R9: A warp whose warp_done_i bit is 1 is never issued again; once all warps of a block are done, their contexts are free from the next cycle.
- R10: warp_done_i and bar_arrive_i bits for unallocated contexts have no effect.
- R11: A warp that stays runnable is issued within NUM_WARPS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatcher requests room for a block |
| alloc_threads_i | input | THR_W (9) | Thread count of the requested block |
| alloc_grant_o | output | 1 | Request accepted this cycle |
| alloc_block_o | output | WID (4) | Tag given to the accepted block |
| warp_done_i | input | NUM_WARPS (12) | Per-warp finished pulse |
| bar_arrive_i | input | NUM_WARPS (12) | Per-warp barrier arrival pulse |
| stall_i | input | NUM_WARPS (12) | Per-warp not-ready level |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_warp_o | output | WID (4) | Context index of the issued warp |
| issue_block_o | output | WID (4) | Block tag of the issued warp |
| issue_lane_base_o | output | BASE_W (9) | First thread index of the issued warp in its block |

## Verification
Grant, granted tag and the whole issue output are combinational on the current state and inputs, so they are due in the very cycle the inputs are applied; allocation, arrival, completion and release take effect at the next rising edge. The bench drives inputs just after the falling edge, samples all outputs one nanosecond later, compares them with a behavioural model of the requirements, and only then advances the model to the state due after the coming rising edge. Directed checks read the same samples, so a warp held at a barrier is expected absent from the first sample after its arrival and a released block is expected back from the first sample after the last arrival.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int unsigned LANES_PER_WARP = 32;

  function automatic int warps_needed(input int threads, input int lanes);
    return (threads + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/warp_alloc.sv
module warp_alloc
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 12,
  parameter int unsigned LANES     = 32,
  parameter int unsigned WID       = 4,
  parameter int unsigned THR_W     = 9
) (
  input  logic [NUM_WARPS-1:0] busy_i,
  input  logic                 req_valid_i,
  input  logic [THR_W-1:0]     req_threads_i,
  output logic                 grant_o,
  output logic [WID-1:0]       block_o,
  output logic [NUM_WARPS-1:0] take_o,
  output logic [WID-1:0]       rank_o [NUM_WARPS]
);
  always_comb begin
    int  need;
    int  free_cnt;
    int  taken;
    logic found;
    need     = warps_needed(int'(req_threads_i), int'(LANES));
    free_cnt = 0;
    for (int w = 0; w < int'(NUM_WARPS); w++)
      if (!busy_i[w]) free_cnt++;
    grant_o = req_valid_i && (req_threads_i != '0) &&
              (need <= int'(NUM_WARPS)) && (need <= free_cnt);
    block_o = '0;
    take_o  = '0;
    found   = 1'b0;
    taken   = 0;
    for (int w = 0; w < int'(NUM_WARPS); w++) begin
      rank_o[w] = '0;
      if (grant_o && !busy_i[w] && taken < need) begin
        take_o[w] = 1'b1;
        rank_o[w] = WID'(taken);
        if (!found) begin
          block_o = WID'(w);
          found   = 1'b1;
        end
        taken++;
      end
    end
  end
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
  parameter int unsigned NUM_WARPS = 12,
  parameter int unsigned WID       = 4
) (
  input  logic [NUM_WARPS-1:0] alloc_i,
  input  logic [NUM_WARPS-1:0] done_i,
  input  logic [NUM_WARPS-1:0] wait_i,
  input  logic [WID-1:0]       tag_i [NUM_WARPS],
  input  logic [NUM_WARPS-1:0] arrive_req_i,
  input  logic [NUM_WARPS-1:0] done_req_i,
  output logic [NUM_WARPS-1:0] arrive_o,
  output logic [NUM_WARPS-1:0] finish_o,
  output logic [NUM_WARPS-1:0] release_o,
  output logic [NUM_WARPS-1:0] block_done_o
);
  // only live, not yet waiting warps may arrive; only live warps may finish
  assign arrive_o = arrive_req_i & alloc_i & ~done_i & ~wait_i;
  assign finish_o = done_req_i & alloc_i & ~done_i;

  always_comb begin
    for (int w = 0; w < int'(NUM_WARPS); w++) begin
      release_o[w]    = alloc_i[w];
      block_done_o[w] = alloc_i[w];
      for (int v = 0; v < int'(NUM_WARPS); v++) begin
        if (alloc_i[v] && tag_i[v] == tag_i[w]) begin
          if (!done_i[v] && !(wait_i[v] || arrive_o[v])) release_o[w] = 1'b0;
          if (!(done_i[v] || finish_o[v])) block_done_o[w] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int unsigned NUM_WARPS = 12,
  parameter int unsigned WID       = 4
) (
  input  logic [NUM_WARPS-1:0] req_i,
  input  logic [WID-1:0]       last_i,
  output logic                 valid_o,
  output logic [WID-1:0]       idx_o
);
  always_comb begin
    int   cand;
    logic hit;
    hit   = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= int'(NUM_WARPS); k++) begin
      cand = (int'(last_i) + k) % int'(NUM_WARPS);
      if (!hit && req_i[cand]) begin
        hit   = 1'b1;
        idx_o = WID'(cand);
      end
    end
    valid_o = hit;
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 12,
  parameter int unsigned LANES     = LANES_PER_WARP,
  localparam int unsigned WID      = $clog2(NUM_WARPS),
  localparam int unsigned THR_W    = $clog2(NUM_WARPS * LANES + 1),
  localparam int unsigned BASE_W   = $clog2(NUM_WARPS * LANES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_valid_i,
  input  logic [THR_W-1:0]     alloc_threads_i,
  output logic                 alloc_grant_o,
  output logic [WID-1:0]       alloc_block_o,
  input  logic [NUM_WARPS-1:0] warp_done_i,
  input  logic [NUM_WARPS-1:0] bar_arrive_i,
  input  logic [NUM_WARPS-1:0] stall_i,
  output logic                 issue_valid_o,
  output logic [WID-1:0]       issue_warp_o,
  output logic [WID-1:0]       issue_block_o,
  output logic [BASE_W-1:0]    issue_lane_base_o
);
  logic [NUM_WARPS-1:0] alloc_q, done_q, wait_q;
  logic [WID-1:0]       tag_q  [NUM_WARPS];
  logic [WID-1:0]       rank_q [NUM_WARPS];
  logic [WID-1:0]       last_q;

  logic [NUM_WARPS-1:0] take, arrive_eff, finish_eff, release_blk, block_done;
  logic [WID-1:0]       take_rank [NUM_WARPS];
  logic [NUM_WARPS-1:0] runnable;
  logic                 pick_valid;
  logic [WID-1:0]       pick_idx;

  warp_alloc #(
    .NUM_WARPS(NUM_WARPS), .LANES(LANES), .WID(WID), .THR_W(THR_W)
  ) i_alloc (
    .busy_i        (alloc_q),
    .req_valid_i   (alloc_valid_i),
    .req_threads_i (alloc_threads_i),
    .grant_o       (alloc_grant_o),
    .block_o       (alloc_block_o),
    .take_o        (take),
    .rank_o        (take_rank)
  );

  warp_barrier #(
    .NUM_WARPS(NUM_WARPS), .WID(WID)
  ) i_barrier (
    .alloc_i      (alloc_q),
    .done_i       (done_q),
    .wait_i       (wait_q),
    .tag_i        (tag_q),
    .arrive_req_i (bar_arrive_i),
    .done_req_i   (warp_done_i),
    .arrive_o     (arrive_eff),
    .finish_o     (finish_eff),
    .release_o    (release_blk),
    .block_done_o (block_done)
  );

  assign runnable = alloc_q & ~done_q & ~wait_q & ~stall_i;

  warp_rr_pick #(
    .NUM_WARPS(NUM_WARPS), .WID(WID)
  ) i_pick (
    .req_i   (runnable),
    .last_i  (last_q),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign issue_valid_o     = pick_valid;
  assign issue_warp_o      = pick_idx;
  assign issue_block_o     = pick_valid ? tag_q[pick_idx] : '0;
  assign issue_lane_base_o = pick_valid ? BASE_W'(int'(rank_q[pick_idx]) * int'(LANES)) : '0;

  for (genvar w = 0; w < int'(NUM_WARPS); w++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alloc_q[w] <= 1'b0;
        done_q[w]  <= 1'b0;
        wait_q[w]  <= 1'b0;
        tag_q[w]   <= '0;
        rank_q[w]  <= '0;
      end else if (block_done[w]) begin
        alloc_q[w] <= 1'b0;
        done_q[w]  <= 1'b0;
        wait_q[w]  <= 1'b0;
      end else if (take[w]) begin
        alloc_q[w] <= 1'b1;
        done_q[w]  <= 1'b0;
        wait_q[w]  <= 1'b0;
        tag_q[w]   <= alloc_block_o;
        rank_q[w]  <= take_rank[w];
      end else begin
        if (finish_eff[w]) done_q[w] <= 1'b1;
        wait_q[w] <= release_blk[w] ? 1'b0 : (wait_q[w] | arrive_eff[w]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         last_q <= WID'(NUM_WARPS - 1);
    else if (pick_valid) last_q <= pick_idx;
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned NUM_WARPS = 12,
  parameter int unsigned WID       = 4,
  parameter int unsigned THR_W     = 9,
  parameter int unsigned BASE_W    = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 alloc_valid_i,
  input logic [THR_W-1:0]     alloc_threads_i,
  input logic                 alloc_grant_o,
  input logic [NUM_WARPS-1:0] stall_i,
  input logic                 issue_valid_o,
  input logic [WID-1:0]       issue_warp_o,
  input logic [BASE_W-1:0]    issue_lane_base_o,
  input logic [NUM_WARPS-1:0] alloc_q,
  input logic [NUM_WARPS-1:0] done_q,
  input logic [NUM_WARPS-1:0] wait_q,
  input logic [NUM_WARPS-1:0] runnable
);
  assert_grant_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_grant_o |-> (alloc_valid_i && alloc_threads_i != '0));

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |-> (issue_warp_o == '0 && issue_lane_base_o == '0));

  assert_no_stalled_issue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !stall_i[issue_warp_o]);

  assert_no_waiting_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !wait_q[issue_warp_o]);

  assert_live_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (alloc_q[issue_warp_o] && !done_q[issue_warp_o]));

  assert_work_conserving_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (runnable != '0) |-> issue_valid_o);

  for (genvar w = 0; w < int'(NUM_WARPS); w++) begin : g_starve
    int unsigned wait_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_cnt <= 0;
      else if (runnable[w] && !(issue_valid_o && int'(issue_warp_o) == w)) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
    end
    assert_no_starve_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_cnt < NUM_WARPS);
  end
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .WID(WID), .THR_W(THR_W), .BASE_W(BASE_W)
) i_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .alloc_valid_i     (alloc_valid_i),
  .alloc_threads_i   (alloc_threads_i),
  .alloc_grant_o     (alloc_grant_o),
  .stall_i           (stall_i),
  .issue_valid_o     (issue_valid_o),
  .issue_warp_o      (issue_warp_o),
  .issue_lane_base_o (issue_lane_base_o),
  .alloc_q           (alloc_q),
  .done_q            (done_q),
  .wait_q            (wait_q),
  .runnable          (runnable)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;
  localparam int NW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [8:0]    alloc_threads = '0;
  logic [NW-1:0] done_v = '0, arrive_v = '0, stall_v = '0;
  logic          alloc_grant, issue_valid;
  logic [3:0]    alloc_block, issue_warp, issue_block;
  logic [8:0]    issue_base;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  bit m_alloc[NW], m_done[NW], m_wait[NW];
  int m_tag[NW], m_rank[NW];
  int m_last = NW - 1;

  // last samples
  bit obs_valid, obs_grant;
  int obs_warp, obs_base, obs_gblk;

  always #2.5 clk = ~clk;

  warp_issue_sched i_warp_issue_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_threads_i(alloc_threads),
    .alloc_grant_o(alloc_grant), .alloc_block_o(alloc_block),
    .warp_done_i(done_v), .bar_arrive_i(arrive_v), .stall_i(stall_v),
    .issue_valid_o(issue_valid), .issue_warp_o(issue_warp),
    .issue_block_o(issue_block), .issue_lane_base_o(issue_base)
  );

  function automatic void chk(int got, int exp, string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", what, got, exp, cycles);
    end
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog: got %0d cycles expected below %0d", cycles, 50000);
      summary();
    end
  end

  // one clock: compare against model, advance model, clear pulses
  task automatic cyc();
    bit run[NW], aeff[NW], deff[NW], rel[NW], fin[NW], was_free[NW];
    bit ev, eg;
    int ew, eb, need, freec, taken;
    #1;
    ev = 0; ew = 0;
    for (int w = 0; w < NW; w++) run[w] = m_alloc[w] && !m_done[w] && !m_wait[w] && !stall_v[w];
    for (int k = 1; k <= NW; k++) begin
      int c = (m_last + k) % NW;
      if (!ev && run[c]) begin ev = 1; ew = c; end
    end
    need = (int'(alloc_threads) + 31) / 32;
    freec = 0;
    for (int w = 0; w < NW; w++) if (!m_alloc[w]) freec++;
    eg = alloc_valid && alloc_threads != 0 && need <= NW && need <= freec;
    eb = 0;
    if (eg) for (int w = NW - 1; w >= 0; w--) if (!m_alloc[w]) eb = w;

    chk(int'(issue_valid), int'(ev), "R4 issue_valid");
    chk(int'(issue_warp), ew, "R5 issue_warp");
    chk(int'(issue_block), ev ? m_tag[ew] : 0, "R3 issue_block");
    chk(int'(issue_base), ev ? m_rank[ew] * 32 : 0, "R3 issue_lane_base");
    chk(int'(alloc_grant), int'(eg), "R2 alloc_grant");
    chk(int'(alloc_block), eb, "R2 alloc_block");
    obs_valid = issue_valid; obs_warp = int'(issue_warp); obs_base = int'(issue_base);
    obs_grant = alloc_grant; obs_gblk = int'(alloc_block);

    if (ev) m_last = ew;
    for (int w = 0; w < NW; w++) begin
      aeff[w] = arrive_v[w] && m_alloc[w] && !m_done[w] && !m_wait[w];
      deff[w] = done_v[w] && m_alloc[w] && !m_done[w];
      was_free[w] = !m_alloc[w];
    end
    for (int w = 0; w < NW; w++) begin
      rel[w] = m_alloc[w]; fin[w] = m_alloc[w];
      for (int v = 0; v < NW; v++)
        if (m_alloc[v] && m_tag[v] == m_tag[w]) begin
          if (!m_done[v] && !(m_wait[v] || aeff[v])) rel[w] = 0;
          if (!(m_done[v] || deff[v])) fin[w] = 0;
        end
    end
    for (int w = 0; w < NW; w++) begin
      if (fin[w]) begin m_alloc[w] = 0; m_done[w] = 0; m_wait[w] = 0; end
      else if (m_alloc[w]) begin
        if (deff[w]) m_done[w] = 1;
        m_wait[w] = rel[w] ? 0 : (m_wait[w] || aeff[w]);
      end
    end
    taken = 0;
    if (eg) for (int w = 0; w < NW; w++)
      if (was_free[w] && taken < need) begin
        m_alloc[w] = 1; m_done[w] = 0; m_wait[w] = 0;
        m_tag[w] = eb; m_rank[w] = taken; taken++;
      end
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0; done_v = '0; arrive_v = '0;
  endtask

  task automatic req(int threads);
    alloc_valid = 1; alloc_threads = 9'(threads);
  endtask

  initial begin
    int mask;
    for (int w = 0; w < NW; w++) begin
      m_alloc[w] = 0; m_done[w] = 0; m_wait[w] = 0; m_tag[w] = 0; m_rank[w] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(int'(issue_valid), 0, "R1 reset issue_valid");
    chk(int'(alloc_grant), 0, "R1 reset alloc_grant");
    @(negedge clk);
    rst_n = 1;
    cyc();

    // R2: illegal sizes refused while everything is free
    req(0);   cyc(); chk(int'(obs_grant), 0, "R2 zero threads refused");
    req(400); cyc(); chk(int'(obs_grant), 0, "R2 oversize refused");
    req(128); cyc(); chk(int'(obs_grant), 1, "R2 128 threads granted");
    chk(obs_gblk, 0, "R2 first block tag");
    // R5: round-robin over warps 0..3
    for (int i = 0; i < 8; i++) begin
      cyc(); chk(obs_warp, i % 4, "R5 round-robin order");
    end
    req(256); cyc(); chk(int'(obs_grant), 1, "R2 256 threads granted");
    chk(obs_gblk, 4, "R2 second block tag");
    req(33);  cyc(); chk(int'(obs_grant), 0, "R2 full pool refused");

    // R6
    stall_v = '1; cyc(); chk(int'(obs_valid), 0, "R6 all stalled idle");
    stall_v = ~12'h080;
    for (int i = 0; i < 3; i++) begin
      cyc(); chk(obs_warp, 7, "R6 only unstalled warp");
    end

    // R7 / R8: barrier on block 0
    stall_v = 12'hFF0; arrive_v = 12'h007; cyc();
    for (int i = 0; i < 4; i++) begin
      cyc(); chk(obs_warp, 3, "R7 waiting warps held");
    end
    arrive_v = 12'h008; cyc();
    mask = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(); if (obs_valid) mask |= (1 << obs_warp);
    end
    chk(mask, 15, "R8 whole block released");

    // R9: finish block 0, then reuse its contexts
    done_v = 12'h00F; cyc();
    cyc(); chk(int'(obs_valid), 0, "R9 finished warps not issued");
    req(64); cyc(); chk(int'(obs_grant), 1, "R9 freed contexts granted");
    chk(obs_gblk, 0, "R9 reused block tag");
    stall_v = 12'hFFC;
    for (int i = 0; i < 4; i++) begin
      cyc(); chk(obs_base, obs_warp * 32, "R3 lane base from position");
    end

    // R10: pulses on unallocated contexts 2,3 are dropped
    done_v = 12'h00C; arrive_v = 12'h00C; cyc();
    req(64); cyc(); chk(obs_gblk, 2, "R10 block tag after ignored pulses");
    stall_v = 12'hFF3;
    for (int i = 0; i < 4; i++) begin
      cyc(); chk(int'(obs_valid && (obs_warp == 2 || obs_warp == 3)), 1, "R10 new warps runnable");
    end

    // mixed traffic against the model (R2..R11)
    for (int i = 0; i < 3000; i++) begin
      stall_v = NW'($urandom & $urandom);
      for (int w = 0; w < NW; w++) begin
        arrive_v[w] = ($urandom_range(0, 7) == 0);
        done_v[w]   = ($urandom_range(0, 47) == 0);
      end
      if ($urandom_range(0, 5) == 0) req($urandom_range(0, 420));
      cyc();
    end
    summary();
  end
endmodule